// File: doc/BRIEF.md
# Three-Position Combination Lock Controller

This block checks a sequence of three entered values against three codes fixed at elaboration. Each entered value arrives together with a one-cycle strobe. A Moore controller picks which stored code the comparator sees. The controller steps forward on each correct strobed value. It opens after the third correct value.

Any wrong strobed value sends the controller to an error state. Only a synchronous reset leaves that state. The open state also holds until reset. The present state is brought out on a 3-bit port so that the sequence can be observed.

A parameter selects one of two controller realizations with identical port behaviour. One is a 3-bit binary state register whose low bits act as the code select. The other is a 4-bit one-hot register that advances by shifting right and is cleared by a load on a mismatch.

Top module: `combo_lock`

## Requirements
- R1: With `rst` high at a clock edge, the next state is the first-position state, reported as `state_o` = 3'b001, with `unlocked` = 0.
- R2: In any of the three entry states (`state_o` 001, 010, 011), a clock edge with `key_valid` low leaves `state_o` unchanged, whatever `key_in` is.
- R3: A strobed value equal to the expected code advances the state: 001 to 010, 010 to 011, and 011 to the open state 111.
- R4: A strobed value that differs from the expected code, in any entry state, moves the state to the error state 000.
- R5: `unlocked` is 1 exactly when `state_o` is 111. The open state persists under any inputs until `rst`.
- R6: The error state 000 persists under any inputs until `rst`, with `unlocked` = 0.
- R7: The expected code depends on the position: `CODE_A` in state 001, `CODE_B` in 010, `CODE_C` in 011. A value that is correct for a different position counts as a mismatch.
- R8: The binary realization (`ONE_HOT`=0) and the one-hot shift realization (`ONE_HOT`=1) give the same `state_o` and `unlocked` for the same input sequence.
- R9: `rst` takes priority over a simultaneous strobe, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to the first-position state |
| key_valid | input | 1 | One-cycle strobe marking a fresh entered value |
| key_in | input | CODE_W | Entered value |
| unlocked | output | 1 | 1 while the lock is open |
| state_o | output | 3 | Present state in binary encoding (001, 010, 011, 111, 000) |

## Verification
The correct three-value sequence is applied in two ways:
- back to back, and
- with idle cycles between the values, which separates advancing on the strobe from advancing on every clock.

A wrong value is tried at each of the three positions. In two of these cases the wrong value is the code that belongs to another position, which shows that the comparison really depends on the position.

Strobes are then given while the lock is open or in error, to show that both states absorb them. Reset is applied together with a strobe from the open, error and middle states. Every step is compared for both realizations at once, so any divergence between the encodings is reported.

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE_A = CODE_W'(3),
  parameter logic [CODE_W-1:0] CODE_B = CODE_W'(9),
  parameter logic [CODE_W-1:0] CODE_C = CODE_W'(5),
  parameter bit ONE_HOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_valid,
  input  logic [CODE_W-1:0] key_in,
  output logic              unlocked,
  output logic [2:0]        state_o
);
  logic [1:0]        sel;
  logic [CODE_W-1:0] want;
  logic              match;

  always_comb begin
    case (sel)
      2'b10:   want = CODE_B;
      2'b11:   want = CODE_C;
      default: want = CODE_A;
    endcase
  end

  assign match = (key_in == want);

  generate
    if (ONE_HOT) begin : g_shift
      logic [3:0] sr;
      logic       load, shift;

      assign shift = ~sr[0] & key_valid;
      assign load  = rst | (~match & ~sr[0] & key_valid);

      always_ff @(posedge clk) begin
        if (load)       sr <= rst ? 4'b1000 : 4'b0000;
        else if (shift) sr <= {1'b0, sr[3:1]};
      end

      assign sel      = {~sr[3], ~sr[2]};
      assign unlocked = sr[0];

      always_comb begin
        case (sr)
          4'b1000: state_o = 3'b001;
          4'b0100: state_o = 3'b010;
          4'b0010: state_o = 3'b011;
          4'b0001: state_o = 3'b111;
          default: state_o = 3'b000;
        endcase
      end
    end else begin : g_binary
      logic [2:0] st, nx;

      always_comb begin
        nx = st;
        if (rst)
          nx = 3'b001;
        else if (key_valid && st != 3'b111 && st != 3'b000) begin
          if (!match)              nx = 3'b000;
          else if (st == 3'b011)   nx = 3'b111;
          else                     nx = st + 3'd1;
        end
      end

      always_ff @(posedge clk) st <= nx;

      assign sel      = st[1:0];
      assign unlocked = st[2];
      assign state_o  = st;
    end
  endgenerate
endmodule

module combo_lock_chk #(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE_A = CODE_W'(3),
  parameter logic [CODE_W-1:0] CODE_B = CODE_W'(9),
  parameter logic [CODE_W-1:0] CODE_C = CODE_W'(5)
) (
  input logic              clk,
  input logic              rst,
  input logic              key_valid,
  input logic [CODE_W-1:0] key_in,
  input logic              unlocked,
  input logic [2:0]        state_o
);
  a_r1_reset_entry: assert property (@(posedge clk) rst |=> state_o == 3'b001 && !unlocked);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!key_valid && (state_o == 3'b001 || state_o == 3'b010 || state_o == 3'b011)) |=> $stable(state_o));

  a_r3_last_digit: assert property (@(posedge clk) disable iff (rst)
    (key_valid && state_o == 3'b011 && key_in == CODE_C) |=> state_o == 3'b111);

  a_r4_first_wrong: assert property (@(posedge clk) disable iff (rst)
    (key_valid && state_o == 3'b001 && key_in != CODE_A) |=> state_o == 3'b000);

  a_r7_second_wrong: assert property (@(posedge clk) disable iff (rst)
    (key_valid && state_o == 3'b010 && key_in != CODE_B) |=> state_o == 3'b000);

  a_r5_open_flag: assert property (@(posedge clk) disable iff (rst)
    unlocked == (state_o == 3'b111));

  a_r5_open_sticky: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'b111 |=> state_o == 3'b111);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'b000 |=> state_o == 3'b000);
endmodule

bind combo_lock combo_lock_chk #(.CODE_W(CODE_W), .CODE_A(CODE_A), .CODE_B(CODE_B), .CODE_C(CODE_C))
  u_chk (.clk(clk), .rst(rst), .key_valid(key_valid), .key_in(key_in),
         .unlocked(unlocked), .state_o(state_o));

// File: tb/combo_lock_test.sv
module combo_lock_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A = 4'd3, B = 4'd9, C = 4'd5;

  typedef struct {
    logic [2:0] st;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_valid = 1'b0;
  logic [3:0] key_in = 4'd0;
  logic       unl_b, unl_h;
  logic [2:0] st_b, st_h;
  int         total = 0, bad = 0;
  bit         driver_done = 1'b0;
  item_t      sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  combo_lock #(.CODE_W(4), .CODE_A(A), .CODE_B(B), .CODE_C(C), .ONE_HOT(1'b0)) uut (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_in(key_in),
    .unlocked(unl_b), .state_o(st_b));

  combo_lock #(.CODE_W(4), .CODE_A(A), .CODE_B(B), .CODE_C(C), .ONE_HOT(1'b1)) uut_oh (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_in(key_in),
    .unlocked(unl_h), .state_o(st_h));

  task automatic step(input logic r, input logic v, input logic [3:0] k,
                      input logic [2:0] exp_st, input string req);
    item_t it;
    @(negedge clk);
    rst = r; key_valid = v; key_in = k;
    it.st = exp_st; it.req = req;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic  exp_u;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        it = sb.pop_front();
        exp_u = (it.st == 3'b111);
        total++;
        if (st_b !== it.st || unl_b !== exp_u) begin
          bad++;
          $display("FAIL %s binary: state=%b unlocked=%b expected state=%b unlocked=%b",
                   it.req, st_b, unl_b, it.st, exp_u);
        end
        total++;
        if (st_h !== it.st || unl_h !== exp_u) begin
          bad++;
          $display("FAIL %s/R8 one-hot: state=%b unlocked=%b expected state=%b unlocked=%b",
                   it.req, st_h, unl_h, it.st, exp_u);
        end
      end
    end
  end

  initial begin : driver
    step(1, 0, 0, 3'b001, "R1");
    step(0, 0, A, 3'b001, "R2");
    step(0, 0, B, 3'b001, "R2");
    step(0, 1, A, 3'b010, "R3");
    step(0, 0, A, 3'b010, "R2");
    step(0, 0, 4'hF, 3'b010, "R2");
    step(0, 1, B, 3'b011, "R3");
    step(0, 0, B, 3'b011, "R2");
    step(0, 1, C, 3'b111, "R3");
    step(0, 1, 4'd0, 3'b111, "R5");
    step(0, 1, A, 3'b111, "R5");
    step(0, 0, 4'd0, 3'b111, "R5");
    step(1, 1, A, 3'b001, "R9");
    step(0, 1, A, 3'b010, "R3");
    step(0, 1, B, 3'b011, "R3");
    step(0, 1, C, 3'b111, "R3");
    step(1, 0, 0, 3'b001, "R1");
    step(0, 1, B, 3'b000, "R7");
    step(0, 1, A, 3'b000, "R6");
    step(0, 0, 0, 3'b000, "R6");
    step(1, 1, B, 3'b001, "R9");
    step(0, 1, A, 3'b010, "R3");
    step(0, 1, 4'd0, 3'b000, "R4");
    step(0, 1, B, 3'b000, "R6");
    step(1, 0, 0, 3'b001, "R1");
    step(0, 1, A, 3'b010, "R3");
    step(0, 1, B, 3'b011, "R3");
    step(0, 1, A, 3'b000, "R7");
    step(1, 0, 0, 3'b001, "R1");
    step(0, 1, A, 3'b010, "R3");
    step(1, 1, B, 3'b001, "R9");
    step(0, 1, A, 3'b010, "R3");
    step(0, 1, B, 3'b011, "R3");
    step(0, 0, C, 3'b011, "R2");
    step(0, 1, C, 3'b111, "R3");
    step(0, 0, 0, 3'b111, "R5");
    repeat (3) @(negedge clk);
    driver_done = 1'b1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!driver_done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!driver_done) begin
      total++;
      bad++;
      $display("FAIL watchdog: driver hung, actual cycles=%0d expected completion", cyc);
    end
    if (sb.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard: actual pending=%0d expected 0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule